// File: doc/BRIEF.md
# SDRAM Command Sequencer with Per-Bank Row Tracking

This block turns single memory requests (read or write, bank, row, column and a burst-size code) into a legal stream of commands for a double-data-rate SDRAM device. It keeps a table of the open row in each bank. A request that hits an open row goes straight to its column command. A request to a closed bank first opens the row. A request to a bank that holds a different row first closes that row and then opens the new one. Every command honours the per-bank counters for activate-to-column delay, precharge time and minimum row-active time.

One command leaves the block per clock. Commands are registered, so the pins change only on the rising edge. A programmable interval counter asks for refresh. When it does, the block stops accepting requests. It closes every open bank with a single precharge-all, waits the precharge time, issues refresh and then waits the refresh cycle time before it accepts traffic again.

The request side is a valid/ready stream. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. The block holds one request at a time, so `req_ready` stays low from the accepting edge until that request's column command has been decided. It is also low while refresh is pending or under way. A source that sees `req_ready` low must hold its request and fields steady. The command pins and `cfg_refi` are plain signals with no handshake.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset the pins carry NOP, `req_ready` is high and every bank is closed, so the first access to any bank starts with an activate.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, refresh 0001. No other code ever appears on these pins.
- R3: A request is taken on an edge with `req_valid` and `req_ready` high. From that edge, `req_ready` stays low until the request's column command is decided. Every accepted request gets exactly one column command, and the column commands come out in acceptance order.
- R4: A request whose row is already open in its bank gets no activate. If its timers and the bus allow it, the column command shows on the pins one cycle after the accepting edge.
- R5: A request to a closed bank gets an activate one cycle after the accepting edge, with the row on `addr` and the bank on `ba`. Its column command follows no earlier than T_RCD cycles after the activate, and exactly T_RCD cycles after it when nothing else delays it.
- R6: A request to a bank that holds a different row first gets a single-bank precharge (addr bit 10 low). The new activate follows exactly T_RP cycles later when unhindered. A precharge is never issued earlier than T_RAS cycles after that bank's activate.
- R7: A read or write carries the column on addr[9:0], with addr bit 10 and every higher bit low. Read or write is chosen by `req_write` (1 means write).
- R8: The burst code maps as follows: 0 gives 2 words, 1 gives 4 words, 2 and 3 give 8 words. A column command or precharge comes no earlier than words/2 cycles after the previous column command.
- R9: With `cfg_refi` = N > 0, refresh is requested every N cycles, so in an idle system consecutive refresh commands are exactly N cycles apart. With `cfg_refi` = 0, no refresh is issued.
- R10: Before a refresh, every open bank is closed with one precharge carrying addr bit 10 high. The refresh issues only when all banks are closed and T_RP has passed. `req_ready` is low from the refresh command until T_RFC cycles after it, and no other command is issued in that window.
- R11: After a refresh every bank is closed, so an access to a row that was open before the refresh starts with an activate.
- R12: Banks are independent. Opening or using a row in one bank leaves the open row of every other bank in place, so it still hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything acts on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Target column |
| req_burst | input | 2 | Burst code (0:2, 1:4, 2/3:8 words) |
| cfg_refi | input | 16 | Refresh interval in cycles, 0 disables |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 13 | Multiplexed row/column address |

## Verification
The bench builds the block with T_RCD = 3, T_RP = 3, T_RAS = 7 and T_RFC = 9. These values are short enough that hit, closed-bank and miss sequences, and their exact cycle offsets, resolve within a few cycles. T_RAS is larger than T_RCD plus the shortest burst gap, so a back-to-back miss to the same bank is held by the row-active limit and not by the bus. The refresh interval is switched between 0, 40 and 97 at run time. This lets one run show exact refresh spacing in an idle system, complete silence with refresh disabled, and refreshes interleaved with random traffic that mixes hits, misses and all four burst codes.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // Command code on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001
  } sdram_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SERVE,
    ST_REF,
    ST_RFC
  } seq_state_e;

  // Bus-occupancy reload for a burst code: (words/2) - 1
  function automatic logic [1:0] burst_hold(input logic [1:0] code);
    case (code)
      2'd0:    burst_hold = 2'd0;
      2'd1:    burst_hold = 2'd1;
      default: burst_hold = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int ROW_W = 13,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             col_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             col_ok_o,
  output logic             pre_ok_o,
  output logic             act_ok_o
);

  localparam int T_MAX1 = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int T_MAX  = (T_MAX1 > T_RAS) ? T_MAX1 : T_RAS;
  localparam int CW     = (T_MAX < 2) ? 1 : $clog2(T_MAX + 1);

  logic          open_q;
  logic [ROW_W-1:0] row_q;
  logic [CW-1:0] rcd_q, ras_q, rp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
      rcd_q  <= '0;
      ras_q  <= '0;
      rp_q   <= '0;
    end else begin
      if (act_i) begin
        open_q <= 1'b1;
        row_q  <= row_i;
        rcd_q  <= CW'(T_RCD - 1);
        ras_q  <= CW'(T_RAS - 1);
      end else begin
        if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
        if (ras_q != '0) ras_q <= ras_q - 1'b1;
      end
      if (pre_i) begin
        open_q <= 1'b0;
        rp_q   <= CW'(T_RP - 1);
      end else if (rp_q != '0) begin
        rp_q <= rp_q - 1'b1;
      end
    end
  end

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign col_ok_o = open_q && (rcd_q == '0);
  assign pre_ok_o = open_q && (ras_q == '0);
  assign act_ok_o = !open_q && (rp_q == '0);

  // R5: a column command only reaches an open bank whose activate delay has run out
  p_col_after_rcd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    col_i |-> (open_q && rcd_q == '0));
  // R5: an activate records its row and opens the bank
  p_act_loads_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> (open_q && row_q == $past(row_i)));
  // R6: an activate only reaches a closed bank after its precharge time
  p_act_after_rp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> (!open_q && rp_q == '0));
  // R6: a precharge only reaches an open bank after its row-active time
  p_pre_after_ras_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pre_i |-> (open_q && ras_q == '0));

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int REFI_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REFI_W-1:0] cfg_refi,
  input  logic              ref_issued,
  output logic              pending_o
);

  logic [REFI_W-1:0] cnt_q;
  logic              pend_q;
  logic              hit;

  assign hit = (cfg_refi != '0) && (cnt_q >= cfg_refi - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (cfg_refi == '0 || hit) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
      pend_q <= (pend_q && !ref_issued) || hit;
    end
  end

  assign pending_o = pend_q;

  // R9: a new refresh request only rises while the interval is enabled
  p_pending_needs_refi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> ($past(cfg_refi) != '0));

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int REFI_W    = 16,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 7,
  parameter int T_RFC     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [1:0]        req_burst,
  input  logic [REFI_W-1:0] cfg_refi,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [$clog2(NUM_BANKS)-1:0] ba,
  output logic [ADDR_W-1:0] addr
);

  localparam int BA_W  = $clog2(NUM_BANKS);
  localparam int RFC_W = (T_RFC < 2) ? 1 : $clog2(T_RFC + 1);

  seq_state_e state_q, state_d;

  // held request
  logic             h_write;
  logic [BA_W-1:0]  h_bank;
  logic [ROW_W-1:0] h_row;
  logic [COL_W-1:0] h_col;
  logic [1:0]       h_burst;

  // bank table
  logic [NUM_BANKS-1:0] b_open, b_col_ok, b_pre_ok, b_act_ok;
  logic [ROW_W-1:0]     b_row [NUM_BANKS];
  logic [NUM_BANKS-1:0] act_v, pre_v, col_v;

  logic             ref_pending, ref_go;
  logic [1:0]       bus_q;
  logic             bus_idle, bus_load;
  logic [RFC_W-1:0] rfc_q;

  sdram_cmd_e      cmd_q, cmd_d;
  logic [BA_W-1:0] ba_q, ba_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  logic hit_row, accept;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdram_bank_slot #(
      .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)
    ) slot_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_i   (act_v[g]),
      .pre_i   (pre_v[g]),
      .col_i   (col_v[g]),
      .row_i   (h_row),
      .open_o  (b_open[g]),
      .row_o   (b_row[g]),
      .col_ok_o(b_col_ok[g]),
      .pre_ok_o(b_pre_ok[g]),
      .act_ok_o(b_act_ok[g])
    );
  end

  sdram_refresh_timer #(.REFI_W(REFI_W)) refi_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_refi  (cfg_refi),
    .ref_issued(ref_go),
    .pending_o (ref_pending)
  );

  assign req_ready = (state_q == ST_IDLE) && !ref_pending;
  assign accept    = req_valid && req_ready;
  assign bus_idle  = (bus_q == 2'd0);
  assign hit_row   = b_open[h_bank] && (b_row[h_bank] == h_row);

  always_comb begin
    state_d  = state_q;
    cmd_d    = CMD_NOP;
    ba_d     = '0;
    addr_d   = '0;
    act_v    = '0;
    pre_v    = '0;
    col_v    = '0;
    ref_go   = 1'b0;
    bus_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (ref_pending)    state_d = ST_REF;
        else if (req_valid) state_d = ST_SERVE;
      end
      ST_SERVE: begin
        if (hit_row) begin
          if (b_col_ok[h_bank] && bus_idle) begin
            cmd_d              = h_write ? CMD_WR : CMD_RD;
            ba_d               = h_bank;
            addr_d[COL_W-1:0]  = h_col;
            col_v[h_bank]      = 1'b1;
            bus_load           = 1'b1;
            state_d            = ST_IDLE;
          end
        end else if (b_open[h_bank]) begin
          if (b_pre_ok[h_bank] && bus_idle) begin
            cmd_d         = CMD_PRE;
            ba_d          = h_bank;
            pre_v[h_bank] = 1'b1;
          end
        end else if (b_act_ok[h_bank]) begin
          cmd_d             = CMD_ACT;
          ba_d              = h_bank;
          addr_d[ROW_W-1:0] = h_row;
          act_v[h_bank]     = 1'b1;
        end
      end
      ST_REF: begin
        if (|b_open) begin
          if (((b_pre_ok | ~b_open) == '1) && bus_idle) begin
            cmd_d          = CMD_PRE;
            addr_d[AP_BIT] = 1'b1;
            pre_v          = b_open;
          end
        end else if (&b_act_ok) begin
          cmd_d   = CMD_REF;
          ref_go  = 1'b1;
          state_d = ST_RFC;
        end
      end
      ST_RFC: begin
        if (rfc_q == '0) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
      bus_q   <= '0;
      rfc_q   <= '0;
      h_write <= 1'b0;
      h_bank  <= '0;
      h_row   <= '0;
      h_col   <= '0;
      h_burst <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      addr_q  <= addr_d;
      if (bus_load)           bus_q <= burst_hold(h_burst);
      else if (bus_q != 2'd0) bus_q <= bus_q - 2'd1;
      if (ref_go)             rfc_q <= RFC_W'(T_RFC - 1);
      else if (rfc_q != '0)   rfc_q <= rfc_q - 1'b1;
      if (accept) begin
        h_write <= req_write;
        h_bank  <= req_bank;
        h_row   <= req_row;
        h_col   <= req_col;
        h_burst <= req_burst;
      end
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign ba   = ba_q;
  assign addr = addr_q;

  // R2: at most one kind of command is decided per cycle
  p_one_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|act_v, |pre_v, |col_v, ref_go}));
  // R8: a column command waits for the previous burst to leave the bus
  p_bus_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|col_v) |-> (bus_q == 2'd0));
  // R10: refresh only with every bank closed
  p_ref_all_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_go |-> (b_open == '0));
  // R10: a refresh on the pins is never accompanied by request acceptance
  p_ref_blocks_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_REF) |-> !req_ready);
  // R3: a held request blocks further acceptance
  p_serve_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

endmodule

// File: tb/sdram_cmd_seq_tb_top.sv
module sdram_cmd_seq_tb_top;

  localparam int T_RCD = 3;
  localparam int T_RP  = 3;
  localparam int T_RAS = 7;
  localparam int T_RFC = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic [1:0]  req_burst = '0;
  logic [15:0] cfg_refi = '0;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;

  always #10 clk = ~clk;

  sdram_cmd_seq #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RFC(T_RFC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_burst(req_burst), .cfg_refi(cfg_refi), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr));

  typedef struct {int bank; int row; int col; int wr; int gap;} req_t;
  req_t expq[$];

  int cyc = 0;
  int checks = 0, errors = 0;
  bit done = 0;
  bit m_open[4];
  int m_row[4], last_act[4], last_pre[4];
  int last_pre_any = -1000, last_col = -1000, last_gap = 1;
  int last_ref = -1000, prev_ref = -1000, ref_cnt = 0;
  int ev_act = -1, ev_pre = -1, ev_col = -1, act_cnt = 0;
  int pre_gap_seen = 0, col_gap_seen = 0;
  bit preall_seen = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int gap_of(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // pin-level monitor with an independent device model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] c;
      int b;
      c = {cs_n, ras_n, cas_n, we_n};
      b = int'(ba);
      if (cyc - last_ref >= 0 && cyc - last_ref < T_RFC) begin
        chk(!req_ready, "R10", "ready during refresh window", int'(req_ready), 0);
        if (cyc != last_ref) chk(c == 4'b0111, "R10", "command inside refresh window", int'(c), 7);
      end
      case (c)
        4'b0111: ;
        4'b0011: begin
          chk(!m_open[b], "R5", "activate to open bank", int'(m_open[b]), 0);
          chk(cyc - last_pre[b] >= T_RP, "R6", "precharge to activate", cyc - last_pre[b], T_RP);
          m_open[b] = 1; m_row[b] = int'(addr); last_act[b] = cyc;
          ev_act = cyc; act_cnt++;
        end
        4'b0010: begin
          chk(cyc - last_col >= last_gap, "R8", "column to precharge", cyc - last_col, last_gap);
          if (addr[10]) begin
            preall_seen = 1;
            for (int k = 0; k < 4; k++) if (m_open[k]) begin
              chk(cyc - last_act[k] >= T_RAS, "R6", "row active time (all)", cyc - last_act[k], T_RAS);
              m_open[k] = 0; last_pre[k] = cyc;
            end
          end else begin
            chk(m_open[b], "R6", "precharge of closed bank", int'(m_open[b]), 1);
            pre_gap_seen = cyc - last_act[b];
            chk(pre_gap_seen >= T_RAS, "R6", "row active time", pre_gap_seen, T_RAS);
            m_open[b] = 0; last_pre[b] = cyc;
          end
          last_pre_any = cyc; ev_pre = cyc;
        end
        4'b0101, 4'b0100: begin
          req_t e;
          chk(m_open[b], "R4", "column to closed bank", int'(m_open[b]), 1);
          chk(cyc - last_act[b] >= T_RCD, "R5", "activate to column", cyc - last_act[b], T_RCD);
          col_gap_seen = cyc - last_col;
          chk(col_gap_seen >= last_gap, "R8", "column spacing", col_gap_seen, last_gap);
          chk(addr[12:10] == 3'b000, "R7", "upper column address bits", int'(addr[12:10]), 0);
          if (expq.size() == 0) begin
            chk(0, "R3", "column command without request", 1, 0);
            last_gap = 1;
          end else begin
            e = expq.pop_front();
            chk(b == e.bank, "R3", "column bank", b, e.bank);
            chk(int'(addr[9:0]) == e.col, "R7", "column value", int'(addr[9:0]), e.col);
            chk(int'(c == 4'b0100) == e.wr, "R2", "read/write code", int'(c == 4'b0100), e.wr);
            chk(m_row[b] == e.row, "R4", "open row at column", m_row[b], e.row);
            last_gap = e.gap;
          end
          last_col = cyc; ev_col = cyc;
        end
        4'b0001: begin
          for (int k = 0; k < 4; k++)
            chk(!m_open[k], "R10", "refresh with bank open", k, -1);
          chk(cyc - last_pre_any >= T_RP, "R10", "precharge to refresh", cyc - last_pre_any, T_RP);
          chk(!req_ready, "R10", "ready at refresh", int'(req_ready), 0);
          prev_ref = last_ref; last_ref = cyc; ref_cnt++;
        end
        default: chk(0, "R2", "illegal command code", int'(c), 7);
      endcase
    end
  end

  task automatic send(input int bank, input int row, input int col, input int wr,
                      input int burst, output int acc);
    req_t e;
    @(negedge clk);
    req_valid = 1; req_bank = 2'(bank); req_row = 13'(row); req_col = 10'(col);
    req_write = wr[0]; req_burst = 2'(burst);
    while (!req_ready) @(negedge clk);
    acc = cyc + 1;
    e.bank = bank; e.row = row; e.col = col; e.wr = wr; e.gap = gap_of(burst);
    expq.push_back(e);
    @(posedge clk);
    #1 req_valid = 0;
    @(negedge clk);
    chk(!req_ready, "R3", "ready after accept", int'(req_ready), 0);
  endtask

  task automatic drain(input int extra);
    int n = 0;
    while (expq.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    repeat (extra) @(negedge clk);
  endtask

  initial begin
    int acc, acc2, a0, n;
    for (int k = 0; k < 4; k++) begin
      m_open[k] = 0; m_row[k] = 0; last_act[k] = -1000; last_pre[k] = -1000;
    end
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "reset command", int'({cs_n, ras_n, cas_n, we_n}), 7);
    chk(req_ready, "R1", "reset ready", int'(req_ready), 1);

    // R5 closed bank (R1: all closed after reset)
    send(0, 5, 'h12, 0, 0, acc);
    drain(10);
    chk(ev_act == acc + 1, "R5", "activate latency", ev_act - acc, 1);
    chk(ev_col == acc + 1 + T_RCD, "R5", "column after activate", ev_col - acc, 1 + T_RCD);

    // R4 hit
    a0 = act_cnt;
    send(0, 5, 'h34, 1, 2, acc);
    drain(10);
    chk(ev_col == acc + 1, "R4", "hit column latency", ev_col - acc, 1);
    chk(act_cnt == a0, "R4", "no activate on hit", act_cnt - a0, 0);

    // R12 other bank does not disturb bank 0
    send(1, 7, 'h2, 0, 1, acc);
    drain(10);
    a0 = act_cnt;
    send(0, 5, 'h3f, 0, 0, acc);
    drain(10);
    chk(ev_col == acc + 1, "R12", "bank 0 still hits", ev_col - acc, 1);
    chk(act_cnt == a0, "R12", "no activate after other bank", act_cnt - a0, 0);

    // R6 miss
    send(0, 9, 'h1, 1, 0, acc);
    drain(10);
    chk(ev_pre == acc + 1, "R6", "precharge latency", ev_pre - acc, 1);
    chk(ev_act == acc + 1 + T_RP, "R6", "activate after precharge", ev_act - acc, 1 + T_RP);
    chk(ev_col == acc + 1 + T_RP + T_RCD, "R6", "column after miss", ev_col - acc, 1 + T_RP + T_RCD);

    // R6 row-active limit on back-to-back miss
    send(2, 1, 'h5, 0, 0, acc);
    send(2, 2, 'h6, 0, 0, acc2);
    drain(10);
    chk(pre_gap_seen == T_RAS, "R6", "activate to precharge", pre_gap_seen, T_RAS);

    // R8 burst spacing, codes 2 and 3 (8 words)
    send(0, 9, 'h10, 0, 2, acc);
    send(0, 9, 'h11, 0, 3, acc2);
    chk(1, "R8", "", 0, 0);
    drain(6);
    chk(col_gap_seen == 4, "R8", "gap after 8-word burst", col_gap_seen, 4);
    send(0, 9, 'h12, 1, 3, acc);
    drain(6);
    chk(col_gap_seen >= 4, "R8", "gap after reserved code", col_gap_seen, 4);
    send(0, 9, 'h13, 0, 1, acc);
    send(0, 9, 'h14, 0, 0, acc2);
    drain(6);
    chk(col_gap_seen == 2, "R8", "gap after 4-word burst", col_gap_seen, 2);

    // R9/R10 refresh, bank 0 open
    @(negedge clk); cfg_refi = 16'd40;
    n = 0;
    while (ref_cnt < 3 && n < 1000) begin @(negedge clk); n++; end
    chk(ref_cnt >= 3, "R9", "refresh count", ref_cnt, 3);
    chk(last_ref - prev_ref == 40, "R9", "refresh spacing", last_ref - prev_ref, 40);
    chk(preall_seen, "R10", "precharge-all before refresh", int'(preall_seen), 1);
    cfg_refi = 16'd0;
    n = ref_cnt;
    repeat (200) @(negedge clk);
    chk(ref_cnt == n, "R9", "refresh disabled", ref_cnt - n, 0);

    // R11 previously open row must be reopened
    send(0, 9, 'h15, 0, 0, acc);
    drain(10);
    chk(ev_act == acc + 1, "R11", "activate after refresh", ev_act - acc, 1);

    // random traffic with refresh
    @(negedge clk); cfg_refi = 16'd97;
    void'($urandom(32'd12345));
    for (int i = 0; i < 300; i++) begin
      send(int'($urandom % 4), int'($urandom % 4), int'($urandom % 1024),
           int'($urandom % 2), int'($urandom % 4), acc);
      if ($urandom % 4 == 0) repeat ($urandom % 8) @(negedge clk);
    end
    drain(20);
    chk(expq.size() == 0, "R3", "all requests served", expq.size(), 0);
    chk(ref_cnt > n + 3, "R9", "refresh during traffic", ref_cnt - n, 4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R3 actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule